// File: doc/BRIEF.md
# Directory Home Node Controller

This block sits at the home node of a directory-based coherent shared-memory system and owns the directory entries for the memory blocks homed there. Each entry holds a stable state, an owner pointer or a presence vector, and a record of the request it is waiting on. One coherence request can arrive per cycle: a read, a read-exclusive, an upgrade, a writeback, or one of two revision messages from a former owner. The controller updates the entry and issues the resulting messages in the same step.

Three output channels carry those messages. The reply channel goes back to the requester: data, an exclusive grant with a count of pending invalidations, a speculative reply, a NACK or a writeback acknowledgement. The forward channel carries an intervention to the current owner, or written-back data to a requester that is waiting. The invalidation channel carries a sharer mask. Sharers acknowledge invalidations to the requester, not to the home. When a request finds its entry busy, the controller NACKs it instead of queueing it. When a writeback crosses a forwarded intervention, the controller merges the two so that neither operation is lost.

Top module: `dir_home`

## Requirements
- R1: After reset every entry is unowned and every output valid is low. A read to any block then gets an exclusive-data reply with count 0.
- R2: A read or read-exclusive to an unowned block makes the requester the exclusive owner. The reply kind is 2 (exclusive data) with count 0. Request type codes are: read 0, read-exclusive 1, upgrade 2, writeback 3, sharing writeback 4, ownership transfer 5.
- R3: A read to a shared block sets the requester's presence bit and gets reply kind 1 (data).
- R4: A read or read-exclusive to an exclusive block makes the entry busy and gets reply kind 4 (speculative). The same step forwards an intervention to the owner: kind 0 for a read, kind 1 for a read-exclusive. The intervention carries the requester's id and tag.
- R5: A read, read-exclusive or upgrade to a busy entry gets reply kind 5 (NACK) and leaves the entry unchanged.
- R6: A read-exclusive to a shared block makes the requester the exclusive owner. It gets reply kind 2 with a count equal to the number of other sharers. An invalidation goes out whose mask bit i marks node i, and which names the requester.
- R7: An upgrade to a shared block behaves like R6 but gets reply kind 3 (grant without data). An upgrade to an unowned or exclusive block gets a NACK.
- R8: A writeback to an exclusive block makes it unowned and gets reply kind 6 (acknowledge). A writeback to an unowned or shared block is acknowledged and changes nothing.
- R9: A writeback to a busy entry merges with the pending request. Busy-shared becomes shared with only the waiting requester present. Busy-exclusive becomes exclusive owned by the waiting requester. The writer gets kind 6, and the waiting requester gets forward kind 2 (data) carrying its own tag.
- R10: A sharing writeback from the owner of a busy-shared entry makes it shared by the owner and the requester. An ownership transfer from the owner of a busy-exclusive entry makes the requester the owner. Neither message produces an output.
- R11: A revision message from a node that is not the owner, or one that arrives at an entry that is not busy, is ignored and produces no output.
- R12: Every output appears in the cycle after its request. A reply carries the tag and node of the request that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A request is present this cycle |
| reqType | input | 3 | Request type code (see R2) |
| reqSrc | input | 2 | Node that sent the request |
| reqBlk | input | 3 | Block index within this home |
| reqTag | input | 4 | Requester transaction tag |
| rspValid | output | 1 | Reply to the requester is valid |
| rspKind | output | 3 | Reply kind code |
| rspDst | output | 2 | Node that receives the reply |
| rspTag | output | 4 | Tag echoed from the request |
| rspCnt | output | 3 | Number of invalidation acks to expect |
| fwdValid | output | 1 | Forwarded message is valid |
| fwdKind | output | 2 | Forwarded kind: intervention-shared, intervention-exclusive, data |
| fwdDst | output | 2 | Node that receives the forwarded message |
| fwdReq | output | 2 | Original requester named in the forwarded message |
| fwdTag | output | 4 | Original requester's tag |
| invValid | output | 1 | Invalidation is valid |
| invMask | output | 4 | Nodes to invalidate |
| invReq | output | 2 | Node that collects the acknowledgements |

## Verification
The bench walks blocks through the full cycle of unowned, exclusive, busy, shared and exclusive again. It probes each busy window with competing requests, which a design that queued or served them would answer with data instead of a NACK. It crosses writebacks with outstanding interventions in both busy flavours: a design that dropped the merge would leave the requester without data or strand the entry in busy, and a later read would then be NACKed. It sends revision messages from the wrong node and to entries that are not busy, which a careless design would take as a state change; later reads reveal any such change. It checks invalidation counts and masks with zero, two and three other sharers, including an upgrade in which the requester is the only sharer.

// File: rtl/dir_home_pkg.sv
package dir_home_pkg;

  typedef enum logic [2:0] {
    REQ_RD   = 3'd0,
    REQ_RDX  = 3'd1,
    REQ_UPG  = 3'd2,
    REQ_WB   = 3'd3,
    REQ_SHWB = 3'd4,
    REQ_XFER = 3'd5
  } req_e;

  typedef enum logic [2:0] {
    ST_UN  = 3'd0,
    ST_SH  = 3'd1,
    ST_EX  = 3'd2,
    ST_BSH = 3'd3,
    ST_BEX = 3'd4
  } dir_state_e;

  typedef enum logic [2:0] {
    RSP_NONE  = 3'd0,
    RSP_DATA  = 3'd1,
    RSP_DATEX = 3'd2,
    RSP_UPACK = 3'd3,
    RSP_SPEC  = 3'd4,
    RSP_NACK  = 3'd5,
    RSP_WBACK = 3'd6
  } rsp_e;

  typedef enum logic [1:0] {
    FWD_ISH = 2'd0,
    FWD_IEX = 2'd1,
    FWD_WBD = 2'd2
  } fwd_e;

  typedef struct packed {
    logic       wr;
    dir_state_e nxt;
    logic       ownSrc;
    logic       ownPend;
    logic       presClr;
    logic       presSrc;
    logic       presOwn;
    logic       presPend;
    logic       savePend;
    logic       rspEn;
    rsp_e       rspKind;
    logic       fwdEn;
    fwd_e       fwdKind;
    logic       fwdToPend;
    logic       invEn;
  } strobe_t;

endpackage

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_home_pkg::*;
#(
  parameter int NODES  = 4,
  localparam int NODE_W = $clog2(NODES)
) (
  input  logic              reqValid,
  input  logic [2:0]        reqType,
  input  logic [NODE_W-1:0] reqSrc,
  input  dir_state_e        curState,
  input  logic [NODE_W-1:0] curOwner,
  output strobe_t           stb
);

  logic isBusy;
  logic fromOwner;
  assign isBusy    = (curState == ST_BSH) || (curState == ST_BEX);
  assign fromOwner = (reqSrc == curOwner);

  always_comb begin
    stb     = '0;
    stb.nxt = curState;
    if (reqValid) begin
      case (req_e'(reqType))
        REQ_RD, REQ_RDX: begin
          stb.rspEn = 1'b1;
          if (isBusy) begin
            stb.rspKind = RSP_NACK;                    // R5
          end else if (curState == ST_EX) begin       // R4
            stb.wr       = 1'b1;
            stb.nxt      = (reqType == REQ_RD) ? ST_BSH : ST_BEX;
            stb.savePend = 1'b1;
            stb.rspKind  = RSP_SPEC;
            stb.fwdEn    = 1'b1;
            stb.fwdKind  = (reqType == REQ_RD) ? FWD_ISH : FWD_IEX;
          end else if (curState == ST_SH && reqType == REQ_RD) begin  // R3
            stb.wr      = 1'b1;
            stb.presSrc = 1'b1;
            stb.rspKind = RSP_DATA;
          end else begin                                // R2, R6
            stb.wr      = 1'b1;
            stb.nxt     = ST_EX;
            stb.ownSrc  = 1'b1;
            stb.presClr = 1'b1;
            stb.rspKind = RSP_DATEX;
            stb.invEn   = (curState == ST_SH);
          end
        end
        REQ_UPG: begin                                  // R7
          stb.rspEn = 1'b1;
          if (curState == ST_SH) begin
            stb.wr      = 1'b1;
            stb.nxt     = ST_EX;
            stb.ownSrc  = 1'b1;
            stb.presClr = 1'b1;
            stb.rspKind = RSP_UPACK;
            stb.invEn   = 1'b1;
          end else begin
            stb.rspKind = RSP_NACK;
          end
        end
        REQ_WB: begin                                   // R8, R9
          stb.rspEn   = 1'b1;
          stb.rspKind = RSP_WBACK;
          case (curState)
            ST_EX: begin
              stb.wr      = 1'b1;
              stb.nxt     = ST_UN;
              stb.presClr = 1'b1;
            end
            ST_BSH: begin
              stb.wr        = 1'b1;
              stb.nxt       = ST_SH;
              stb.presClr   = 1'b1;
              stb.presPend  = 1'b1;
              stb.fwdEn     = 1'b1;
              stb.fwdKind   = FWD_WBD;
              stb.fwdToPend = 1'b1;
            end
            ST_BEX: begin
              stb.wr        = 1'b1;
              stb.nxt       = ST_EX;
              stb.ownPend   = 1'b1;
              stb.fwdEn     = 1'b1;
              stb.fwdKind   = FWD_WBD;
              stb.fwdToPend = 1'b1;
            end
            default: ;
          endcase
        end
        REQ_SHWB: begin                                 // R10, R11
          if (curState == ST_BSH && fromOwner) begin
            stb.wr       = 1'b1;
            stb.nxt      = ST_SH;
            stb.presClr  = 1'b1;
            stb.presOwn  = 1'b1;
            stb.presPend = 1'b1;
          end
        end
        REQ_XFER: begin                                 // R10, R11
          if (curState == ST_BEX && fromOwner) begin
            stb.wr      = 1'b1;
            stb.nxt     = ST_EX;
            stb.ownPend = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dir_home_dp.sv
module dir_home_dp
  import dir_home_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  parameter int TAG_W  = 4,
  localparam int NODE_W = $clog2(NODES),
  localparam int BLK_W  = $clog2(BLOCKS),
  localparam int CNT_W  = $clog2(NODES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqType,
  input  logic [NODE_W-1:0] reqSrc,
  input  logic [BLK_W-1:0]  reqBlk,
  input  logic [TAG_W-1:0]  reqTag,
  input  strobe_t           stb,
  output dir_state_e        curState,
  output logic [NODE_W-1:0] curOwner,
  output logic              rspValid,
  output logic [2:0]        rspKind,
  output logic [NODE_W-1:0] rspDst,
  output logic [TAG_W-1:0]  rspTag,
  output logic [CNT_W-1:0]  rspCnt,
  output logic              fwdValid,
  output logic [1:0]        fwdKind,
  output logic [NODE_W-1:0] fwdDst,
  output logic [NODE_W-1:0] fwdReq,
  output logic [TAG_W-1:0]  fwdTag,
  output logic              invValid,
  output logic [NODES-1:0]  invMask,
  output logic [NODE_W-1:0] invReq
);

  dir_state_e        stateQ   [BLOCKS];
  logic [NODE_W-1:0] ownerQ   [BLOCKS];
  logic [NODE_W-1:0] pendQ    [BLOCKS];
  logic [TAG_W-1:0]  pendTagQ [BLOCKS];
  logic [NODES-1:0]  presQ    [BLOCKS];

  logic [NODE_W-1:0] curPend;
  logic [TAG_W-1:0]  curPendTag;
  logic [NODES-1:0]  curPres;
  logic [NODES-1:0]  srcBit;
  logic [NODES-1:0]  nxtPres;
  logic [NODES-1:0]  invMaskC;
  logic [CNT_W-1:0]  invCnt;

  assign curState   = stateQ[reqBlk];
  assign curOwner   = ownerQ[reqBlk];
  assign curPend    = pendQ[reqBlk];
  assign curPendTag = pendTagQ[reqBlk];
  assign curPres    = presQ[reqBlk];
  assign srcBit     = NODES'(1) << reqSrc;

  always_comb begin
    nxtPres = stb.presClr ? '0 : curPres;
    if (stb.presSrc)  nxtPres = nxtPres | srcBit;
    if (stb.presOwn)  nxtPres = nxtPres | (NODES'(1) << curOwner);
    if (stb.presPend) nxtPres = nxtPres | (NODES'(1) << curPend);
  end

  assign invMaskC = curPres & ~srcBit;
  assign invCnt   = CNT_W'($countones(invMaskC));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < BLOCKS; b++) begin
        stateQ[b]   <= ST_UN;
        ownerQ[b]   <= '0;
        pendQ[b]    <= '0;
        pendTagQ[b] <= '0;
        presQ[b]    <= '0;
      end
    end else if (stb.wr) begin
      stateQ[reqBlk] <= stb.nxt;
      presQ[reqBlk]  <= nxtPres;
      if (stb.ownSrc)  ownerQ[reqBlk] <= reqSrc;
      if (stb.ownPend) ownerQ[reqBlk] <= curPend;
      if (stb.savePend) begin
        pendQ[reqBlk]    <= reqSrc;
        pendTagQ[reqBlk] <= reqTag;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspKind  <= '0;
      rspDst   <= '0;
      rspTag   <= '0;
      rspCnt   <= '0;
      fwdValid <= 1'b0;
      fwdKind  <= '0;
      fwdDst   <= '0;
      fwdReq   <= '0;
      fwdTag   <= '0;
      invValid <= 1'b0;
      invMask  <= '0;
      invReq   <= '0;
    end else begin
      rspValid <= stb.rspEn;
      rspKind  <= stb.rspKind;
      rspDst   <= reqSrc;
      rspTag   <= reqTag;
      rspCnt   <= stb.invEn ? invCnt : '0;
      fwdValid <= stb.fwdEn;
      fwdKind  <= stb.fwdKind;
      fwdDst   <= stb.fwdToPend ? curPend : curOwner;
      fwdReq   <= stb.fwdToPend ? curPend : reqSrc;
      fwdTag   <= stb.fwdToPend ? curPendTag : reqTag;
      invValid <= stb.invEn && (invMaskC != '0);
      invMask  <= stb.invEn ? invMaskC : '0;
      invReq   <= reqSrc;
    end
  end

  p_nack_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (curState == ST_BSH || curState == ST_BEX) &&
     (reqType == REQ_RD || reqType == REQ_RDX || reqType == REQ_UPG))
    |=> (rspValid && rspKind == RSP_NACK));

  p_inv_count_r6: assert property (@(posedge clk) disable iff (!rstN)
    invValid |-> (rspValid && $countones(invMask) == int'(rspCnt)));

  p_inv_self_r6: assert property (@(posedge clk) disable iff (!rstN)
    invValid |-> (invMask[invReq] == 1'b0 && invReq == rspDst));

  p_intv_spec_r4: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && fwdKind != FWD_WBD) |-> (rspValid && rspKind == RSP_SPEC && fwdReq == rspDst));

  p_merge_ack_r9: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && fwdKind == FWD_WBD) |-> (rspValid && rspKind == RSP_WBACK));

  p_tag_echo_r12: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqType <= REQ_WB) |=> (rspValid && rspTag == $past(reqTag)));

endmodule

// File: rtl/dir_home.sv
module dir_home
  import dir_home_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  parameter int TAG_W  = 4,
  localparam int NODE_W = $clog2(NODES),
  localparam int BLK_W  = $clog2(BLOCKS),
  localparam int CNT_W  = $clog2(NODES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqType,
  input  logic [NODE_W-1:0] reqSrc,
  input  logic [BLK_W-1:0]  reqBlk,
  input  logic [TAG_W-1:0]  reqTag,
  output logic              rspValid,
  output logic [2:0]        rspKind,
  output logic [NODE_W-1:0] rspDst,
  output logic [TAG_W-1:0]  rspTag,
  output logic [CNT_W-1:0]  rspCnt,
  output logic              fwdValid,
  output logic [1:0]        fwdKind,
  output logic [NODE_W-1:0] fwdDst,
  output logic [NODE_W-1:0] fwdReq,
  output logic [TAG_W-1:0]  fwdTag,
  output logic              invValid,
  output logic [NODES-1:0]  invMask,
  output logic [NODE_W-1:0] invReq
);

  strobe_t           stb;
  dir_state_e        curState;
  logic [NODE_W-1:0] curOwner;

  dir_home_ctrl #(.NODES(NODES)) u_ctrl (
    .reqValid (reqValid),
    .reqType  (reqType),
    .reqSrc   (reqSrc),
    .curState (curState),
    .curOwner (curOwner),
    .stb      (stb)
  );

  dir_home_dp #(.NODES(NODES), .BLOCKS(BLOCKS), .TAG_W(TAG_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqType  (reqType),
    .reqSrc   (reqSrc),
    .reqBlk   (reqBlk),
    .reqTag   (reqTag),
    .stb      (stb),
    .curState (curState),
    .curOwner (curOwner),
    .rspValid (rspValid),
    .rspKind  (rspKind),
    .rspDst   (rspDst),
    .rspTag   (rspTag),
    .rspCnt   (rspCnt),
    .fwdValid (fwdValid),
    .fwdKind  (fwdKind),
    .fwdDst   (fwdDst),
    .fwdReq   (fwdReq),
    .fwdTag   (fwdTag),
    .invValid (invValid),
    .invMask  (invMask),
    .invReq   (invReq)
  );

endmodule

// File: tb/dir_home_bench.sv
module dir_home_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [2:0] reqType = '0;
  logic [1:0] reqSrc = '0;
  logic [2:0] reqBlk = '0;
  logic [3:0] reqTag = '0;
  logic       rspValid;
  logic [2:0] rspKind;
  logic [1:0] rspDst;
  logic [3:0] rspTag;
  logic [2:0] rspCnt;
  logic       fwdValid;
  logic [1:0] fwdKind;
  logic [1:0] fwdDst;
  logic [1:0] fwdReq;
  logic [3:0] fwdTag;
  logic       invValid;
  logic [3:0] invMask;
  logic [1:0] invReq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dir_home u_dir_home (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqType(reqType),
    .reqSrc(reqSrc), .reqBlk(reqBlk), .reqTag(reqTag),
    .rspValid(rspValid), .rspKind(rspKind), .rspDst(rspDst), .rspTag(rspTag),
    .rspCnt(rspCnt), .fwdValid(fwdValid), .fwdKind(fwdKind), .fwdDst(fwdDst),
    .fwdReq(fwdReq), .fwdTag(fwdTag), .invValid(invValid), .invMask(invMask),
    .invReq(invReq)
  );

  typedef struct packed {
    logic [3:0] rq;
    logic [2:0] ty;
    logic [1:0] src;
    logic [2:0] blk;
    logic [3:0] tag;
    logic       rV;
    logic [2:0] rK;
    logic [2:0] cnt;
    logic       fV;
    logic [1:0] fK;
    logic [1:0] fD;
    logic [1:0] fR;
    logic [3:0] fT;
    logic       iV;
    logic [3:0] iM;
  } vec_t;

  localparam int NVEC = 30;
  // fields: req, type, src, blk, tag | rspV, kind, cnt | fwdV, kind, dst, req, tag | invV, mask
  localparam vec_t TBL [NVEC] = '{
    '{2,  0, 0, 0, 1,  1, 2, 0,  0, 0, 0, 0, 0,   0, 0},  // R2 read unowned
    '{4,  0, 1, 0, 2,  1, 4, 0,  1, 0, 0, 1, 2,   0, 0},  // R4 read to exclusive
    '{5,  1, 2, 0, 3,  1, 5, 0,  0, 0, 0, 0, 0,   0, 0},  // R5 rdx to busy
    '{5,  2, 3, 0, 4,  1, 5, 0,  0, 0, 0, 0, 0,   0, 0},  // R5 upgrade to busy
    '{11, 4, 2, 0, 5,  0, 0, 0,  0, 0, 0, 0, 0,   0, 0},  // R11 revision from non-owner
    '{10, 4, 0, 0, 5,  0, 0, 0,  0, 0, 0, 0, 0,   0, 0},  // R10 sharing writeback
    '{3,  0, 2, 0, 6,  1, 1, 0,  0, 0, 0, 0, 0,   0, 0},  // R3 read shared
    '{11, 5, 0, 0, 7,  0, 0, 0,  0, 0, 0, 0, 0,   0, 0},  // R11 transfer while not busy
    '{6,  1, 3, 0, 7,  1, 2, 3,  0, 0, 0, 0, 0,   1, 7},  // R6 rdx shared, three sharers
    '{7,  2, 0, 0, 8,  1, 5, 0,  0, 0, 0, 0, 0,   0, 0},  // R7 upgrade to exclusive
    '{7,  2, 1, 1, 9,  1, 5, 0,  0, 0, 0, 0, 0,   0, 0},  // R7 upgrade to unowned
    '{4,  1, 1, 0, 10, 1, 4, 0,  1, 1, 3, 1, 10,  0, 0},  // R4 rdx to exclusive
    '{9,  3, 3, 0, 11, 1, 6, 0,  1, 2, 1, 1, 10,  0, 0},  // R9 merge busy-exclusive
    '{8,  3, 1, 0, 12, 1, 6, 0,  0, 0, 0, 0, 0,   0, 0},  // R8 writeback from new owner
    '{2,  0, 2, 0, 13, 1, 2, 0,  0, 0, 0, 0, 0,   0, 0},  // R2 block unowned again
    '{4,  0, 3, 0, 14, 1, 4, 0,  1, 0, 2, 3, 14,  0, 0},  // R4 read to exclusive
    '{9,  3, 2, 0, 15, 1, 6, 0,  1, 2, 3, 3, 14,  0, 0},  // R9 merge busy-shared
    '{7,  2, 3, 0, 0,  1, 3, 0,  0, 0, 0, 0, 0,   0, 0},  // R7 upgrade, lone sharer
    '{2,  0, 1, 2, 1,  1, 2, 0,  0, 0, 0, 0, 0,   0, 0},  // R2
    '{4,  1, 2, 2, 2,  1, 4, 0,  1, 1, 1, 2, 2,   0, 0},  // R4
    '{10, 5, 1, 2, 3,  0, 0, 0,  0, 0, 0, 0, 0,   0, 0},  // R10 ownership transfer
    '{4,  0, 0, 2, 4,  1, 4, 0,  1, 0, 2, 0, 4,   0, 0},  // R4 new owner is node 2
    '{10, 4, 2, 2, 5,  0, 0, 0,  0, 0, 0, 0, 0,   0, 0},  // R10 sharing writeback
    '{3,  0, 1, 2, 6,  1, 1, 0,  0, 0, 0, 0, 0,   0, 0},  // R3
    '{7,  2, 1, 2, 7,  1, 3, 2,  0, 0, 0, 0, 0,   1, 5},  // R7 upgrade, two others
    '{11, 4, 1, 2, 8,  0, 0, 0,  0, 0, 0, 0, 0,   0, 0},  // R11 owner but not busy
    '{8,  3, 1, 2, 8,  1, 6, 0,  0, 0, 0, 0, 0,   0, 0},  // R8
    '{2,  1, 3, 2, 9,  1, 2, 0,  0, 0, 0, 0, 0,   0, 0},  // R2 rdx unowned
    '{8,  3, 0, 5, 10, 1, 6, 0,  0, 0, 0, 0, 0,   0, 0},  // R8 stale writeback
    '{8,  0, 0, 5, 11, 1, 2, 0,  0, 0, 0, 0, 0,   0, 0}   // R8 no change seen
  };

  task automatic chk(input int rq, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic send(input logic [2:0] ty, input logic [1:0] src,
                      input logic [2:0] blk, input logic [3:0] tag);
    reqValid = 1'b1;
    reqType  = ty;
    reqSrc   = src;
    reqBlk   = blk;
    reqTag   = tag;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs idle during and right after reset
    chk(1, "rspValid in reset", int'(rspValid), 0);
    chk(1, "fwdValid in reset", int'(fwdValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(1, "invValid idle", int'(invValid), 0);
    chk(1, "rspValid idle", int'(rspValid), 0);

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = TBL[i];
      send(v.ty, v.src, v.blk, v.tag);
      chk(int'(v.rq), "rspValid", int'(rspValid), int'(v.rV));
      if (v.rV) begin
        chk(int'(v.rq), "rspKind", int'(rspKind), int'(v.rK));
        chk(int'(v.rq), "rspDst", int'(rspDst), int'(v.src));
        chk(int'(v.rq), "rspTag", int'(rspTag), int'(v.tag));  // R12
        chk(int'(v.rq), "rspCnt", int'(rspCnt), int'(v.cnt));
      end
      chk(int'(v.rq), "fwdValid", int'(fwdValid), int'(v.fV));
      if (v.fV) begin
        chk(int'(v.rq), "fwdKind", int'(fwdKind), int'(v.fK));
        chk(int'(v.rq), "fwdDst", int'(fwdDst), int'(v.fD));
        chk(int'(v.rq), "fwdReq", int'(fwdReq), int'(v.fR));
        chk(int'(v.rq), "fwdTag", int'(fwdTag), int'(v.fT));
      end
      chk(int'(v.rq), "invValid", int'(invValid), int'(v.iV));
      if (v.iV) begin
        chk(int'(v.rq), "invMask", int'(invMask), int'(v.iM));
        chk(int'(v.rq), "invReq", int'(invReq), int'(v.src));
      end
    end

    // R12: a cycle with no request produces no output
    @(negedge clk);
    chk(12, "rspValid with no request", int'(rspValid), 0);

    // R1: a second reset returns every entry to unowned
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    send(3'd0, 2'd1, 3'd2, 4'd3);
    chk(1, "rspKind after reset", int'(rspKind), 2);
    chk(1, "rspCnt after reset", int'(rspCnt), 0);
    chk(1, "fwdValid after reset", int'(fwdValid), 0);

    done = 1'b1;
    summary();
  end

endmodule